// File: doc/BRIEF.md
# Shared External Bus Arbiter

This block chooses which master owns a shared external bus. Up to six processors and one host processor can drive it. Each master raises its own request line. The arbiter answers with a one-hot grant and with the identity of the current owner. It also tells the local processor, named by an identity input, whether that processor holds the bus.

A run-time mode input selects the priority scheme, either fixed or rotating. The host always ranks above every processor, but only when no lock is held. Moving the bus to a new owner always passes through exactly one dead cycle in which no grant is driven. A lock input freezes the current ownership so that a read-modify-write semaphore sequence cannot be split. An owner that keeps requesting can only lose the bus at a transfer boundary, which a separate input marks.

Top module: `mp_bus_arbiter`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, `grant` is all zero, `owner_id` is 0 and `self_granted` is 0.
- R2: Every change of ownership, including the first grant out of idle, takes one changeover cycle with `grant` zero. A request seen while idle is granted after the second rising edge. `grant` never switches directly from one master to another.
- R3: `grant` is one-hot or all zero at all times. Bit k-1 of `grant` is processor k (k = 1..6) and bit 6 is the host.
- R4: In fixed mode (`rotate_mode` = 0), the requesting processor with the lowest number wins. `proc_req` bit k-1 is processor k. `owner_id` is k for processor k, 7 for the host and 0 when nobody owns the bus.
- R5: In rotating mode (`rotate_mode` = 1), the processor granted most recently drops to the lowest priority. The search starts at the next higher number and wraps around. After reset processor 1 ranks first.
- R6: When no lock is held, a host request ranks above every processor and takes the bus at the next transfer boundary. While the host owns the bus, no processor request displaces it.
- R7: An owner that keeps requesting stays on the bus during any cycle in which `xfer_done` is low, even when a higher-ranked request is pending.
- R8: When the owner drops its request and no lock is held, the bus goes through the changeover cycle to the best pending requester. If nothing is pending, the bus returns to idle.
- R9: While `lock` is high, ownership does not change. The owner keeps the bus even if it drops its request, and all other requests, including the host's, are ignored. A lock raised while the bus is idle prevents any grant.
- R10: `self_granted` is 1 exactly when a grant is active and `owner_id` equals `self_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_req | input | NUM_PROC | Bus request, bit k-1 from processor k |
| host_req | input | 1 | Bus request from the host |
| lock | input | 1 | Hold current ownership, freeze arbitration |
| rotate_mode | input | 1 | 0 fixed priority, 1 rotating priority |
| xfer_done | input | 1 | Current transfer ends this cycle (preemption point) |
| self_id | input | IDW | Identity of the local processor |
| grant | output | NUM_PROC+1 | One-hot grant, bit NUM_PROC is the host |
| owner_id | output | IDW | Identity of the bus owner, 0 when none |
| self_granted | output | 1 | The local processor owns the bus |

## Verification
The two functions that can fall in the same cycle are a lock and a preemption request. The bench sets lock high in the same cycle that a host request, a higher-ranked processor request and a transfer boundary all arrive, and in that cycle the owner also drops its own request. The owner must keep the grant for every locked cycle. The host must then appear only after exactly one dead cycle once the lock falls. A second collision, a boundary at which a higher-ranked request is pending, is judged by checking that the grant holds while the boundary is low and clears for one cycle once the boundary rises.

// File: rtl/arb_pkg.sv
// Package arb_pkg
// Shared types for the shared-bus arbiter.
// Assumes nothing beyond the IEEE 1800-2017 language.
package arb_pkg;

    // Ownership phases of the bus.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,  // nobody owns the bus
        ST_HANDOFF = 2'd1,  // dead changeover cycle, owner chosen
        ST_OWNED   = 2'd2   // grant is active
    } arb_state_e;

endpackage

// File: rtl/arb_winner_pick.sv
// Module arb_winner_pick
// Combinational choice of the best pending requester.
// Master index 0..NUM_PROC-1 is processor 1..NUM_PROC and index NUM_PROC
// is the host. The host always wins when it requests.
// Fixed mode: lowest processor index wins.
// Rotating mode: the search starts one past last_ptr and wraps, so the
// processor at last_ptr ranks last.
// Assumes last_ptr < NUM_PROC.
module arb_winner_pick #(
    parameter int NUM_PROC = 6,
    localparam int MW = $clog2(NUM_PROC + 1),
    localparam int PW = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
    input  logic [NUM_PROC-1:0] proc_req,
    input  logic                host_req,
    input  logic                rotate_mode,
    input  logic [PW-1:0]       last_ptr,
    output logic                win_valid,
    output logic [MW-1:0]       win_idx
);

    logic [MW-1:0] fixed_idx;
    logic [MW-1:0] rot_idx;
    logic          rot_found;

    // Fixed priority: scan downward so the lowest index is kept last.
    always_comb begin
        fixed_idx = '0;
        for (int i = NUM_PROC - 1; i >= 0; i--) begin
            if (proc_req[i]) fixed_idx = MW'(i);
        end
    end

    // Rotating priority: first requester after the last-granted processor.
    always_comb begin
        rot_idx   = '0;
        rot_found = 1'b0;
        for (int k = 1; k <= NUM_PROC; k++) begin
            int idx;
            idx = (int'(last_ptr) + k) % NUM_PROC;
            if (!rot_found && proc_req[idx]) begin
                rot_idx   = MW'(idx);
                rot_found = 1'b1;
            end
        end
    end

    // Final selection: the host ranks above both processor schemes.
    always_comb begin
        win_valid = host_req | (|proc_req);
        if (host_req)         win_idx = MW'(NUM_PROC);
        else if (rotate_mode) win_idx = rot_idx;
        else                  win_idx = fixed_idx;
    end

endmodule

// File: rtl/arb_handoff_fsm.sv
// Module arb_handoff_fsm
// Ownership sequencer. Every change of owner passes through one dead
// ST_HANDOFF cycle. Preemption of a still-requesting owner happens only
// when xfer_done is high. A high lock freezes all decisions except a
// handoff that is already under way.
// Assumes win_idx and win_valid come from arb_winner_pick that is fed by
// the same last_ptr this module keeps.
module arb_handoff_fsm
    import arb_pkg::*;
#(
    parameter int NUM_PROC = 6,
    localparam int MW = $clog2(NUM_PROC + 1),
    localparam int PW = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          xfer_done,
    input  logic          owner_req,
    input  logic          win_valid,
    input  logic [MW-1:0] win_idx,
    output arb_state_e    state,
    output logic [MW-1:0] owner_idx,
    output logic [PW-1:0] last_ptr
);

    localparam logic [PW-1:0] PTR_RESET = PW'(NUM_PROC - 1);

    arb_state_e    state_nx;
    logic [MW-1:0] pend_idx;
    logic [MW-1:0] pend_nx;
    logic          preempt;

    // A still-requesting owner yields only at a boundary to a different winner.
    always_comb begin
        preempt = xfer_done && win_valid && (win_idx != owner_idx);
    end

    // Next-state choice for the ownership sequencer.
    always_comb begin
        state_nx = state;
        pend_nx  = pend_idx;
        unique case (state)
            ST_IDLE: begin
                if (!lock && win_valid) begin
                    state_nx = ST_HANDOFF;
                    pend_nx  = win_idx;
                end
            end
            ST_HANDOFF: begin
                state_nx = ST_OWNED;
            end
            ST_OWNED: begin
                if (lock) begin
                    state_nx = ST_OWNED;
                end else if (!owner_req) begin
                    if (win_valid) begin
                        state_nx = ST_HANDOFF;
                        pend_nx  = win_idx;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else if (preempt) begin
                    state_nx = ST_HANDOFF;
                    pend_nx  = win_idx;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // State, pending owner and current owner registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_idx  <= '0;
            owner_idx <= '0;
        end else begin
            state    <= state_nx;
            pend_idx <= pend_nx;
            if (state == ST_HANDOFF) owner_idx <= pend_idx;
        end
    end

    // Rotating pointer follows the last processor to receive the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ptr <= PTR_RESET;
        end else if (state == ST_HANDOFF && int'(pend_idx) < NUM_PROC) begin
            last_ptr <= PW'(pend_idx);
        end
    end

endmodule

// File: rtl/arb_grant_decode.sv
// Module arb_grant_decode
// Turns the registered owner into the one-hot grant, the owner identity
// (index + 1, 0 when no grant) and the local-ownership flag.
// Assumes owner_idx <= NUM_PROC.
module arb_grant_decode
    import arb_pkg::*;
#(
    parameter int NUM_PROC = 6,
    localparam int MW  = $clog2(NUM_PROC + 1),
    localparam int IDW = $clog2(NUM_PROC + 2)
) (
    input  arb_state_e          state,
    input  logic [MW-1:0]       owner_idx,
    input  logic [IDW-1:0]      self_id,
    output logic [NUM_PROC:0]   grant,
    output logic [IDW-1:0]      owner_id,
    output logic                self_granted
);

    logic active;

    // Grant is driven only in the owned phase.
    always_comb begin
        active = (state == ST_OWNED);
    end

    // One grant line per master, built by a generate loop.
    for (genvar g = 0; g <= NUM_PROC; g++) begin : g_gnt
        always_comb begin
            grant[g] = active && (int'(owner_idx) == g);
        end
    end

    // Owner identity and local ownership flag.
    always_comb begin
        owner_id     = active ? (IDW'(owner_idx) + IDW'(1)) : '0;
        self_granted = active && (owner_id == self_id);
    end

endmodule

// File: rtl/mp_bus_arbiter.sv
// Module mp_bus_arbiter
// Top level of the shared-bus arbiter for NUM_PROC processors and one host.
// Joins the winner picker, the ownership sequencer and the grant decoder.
// Assumes all inputs are synchronous to clk.
module mp_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_PROC = 6,
    localparam int IDW = $clog2(NUM_PROC + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PROC-1:0] proc_req,
    input  logic                host_req,
    input  logic                lock,
    input  logic                rotate_mode,
    input  logic                xfer_done,
    input  logic [IDW-1:0]      self_id,
    output logic [NUM_PROC:0]   grant,
    output logic [IDW-1:0]      owner_id,
    output logic                self_granted
);

    localparam int MW = $clog2(NUM_PROC + 1);
    localparam int PW = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1;

    arb_state_e    state;
    logic [MW-1:0] owner_idx;
    logic [PW-1:0] last_ptr;
    logic          win_valid;
    logic [MW-1:0] win_idx;
    logic [NUM_PROC:0] all_req;
    logic          owner_req;

    // Request vector indexed like grant; pick the owner's own line.
    always_comb begin
        all_req   = {host_req, proc_req};
        owner_req = all_req[owner_idx];
    end

    arb_winner_pick #(.NUM_PROC(NUM_PROC)) u_pick (
        .proc_req    (proc_req),
        .host_req    (host_req),
        .rotate_mode (rotate_mode),
        .last_ptr    (last_ptr),
        .win_valid   (win_valid),
        .win_idx     (win_idx)
    );

    arb_handoff_fsm #(.NUM_PROC(NUM_PROC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (lock),
        .xfer_done (xfer_done),
        .owner_req (owner_req),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .state     (state),
        .owner_idx (owner_idx),
        .last_ptr  (last_ptr)
    );

    arb_grant_decode #(.NUM_PROC(NUM_PROC)) u_dec (
        .state        (state),
        .owner_idx    (owner_idx),
        .self_id      (self_id),
        .grant        (grant),
        .owner_id     (owner_id),
        .self_granted (self_granted)
    );

endmodule

// File: rtl/mp_bus_arbiter_checker.sv
// Module mp_bus_arbiter_checker
// Port-level properties of the shared-bus arbiter, bound to every instance.
module mp_bus_arbiter_checker #(
    parameter int NUM_PROC = 6,
    localparam int IDW = $clog2(NUM_PROC + 2)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PROC-1:0] proc_req,
    input logic                host_req,
    input logic                lock,
    input logic                xfer_done,
    input logic [NUM_PROC:0]   grant,
    input logic [IDW-1:0]      owner_id
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (grant == '0));

    assert_no_direct_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && ($past(grant) != '0)) |-> (grant == $past(grant)));

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_owner_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) == (owner_id == '0)));

    assert_host_preempts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !lock && xfer_done && (grant != '0) && !grant[NUM_PROC])
        |=> (grant == '0));

    assert_hold_midxfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !lock && !xfer_done
         && ((grant & {host_req, proc_req}) != '0)) |=> $stable(grant));

    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && (grant != '0)) |=> $stable(grant));

endmodule

bind mp_bus_arbiter mp_bus_arbiter_checker #(.NUM_PROC(NUM_PROC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .proc_req  (proc_req),
    .host_req  (host_req),
    .lock      (lock),
    .xfer_done (xfer_done),
    .grant     (grant),
    .owner_id  (owner_id)
);

// File: tb/sim_mp_bus_arbiter.sv
`timescale 1ns/1ps
module sim_mp_bus_arbiter;

    localparam int NP  = 6;
    localparam int IDW = $clog2(NP + 2);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] proc_req;
    logic          host_req;
    logic          lock;
    logic          rotate_mode;
    logic          xfer_done;
    logic [IDW-1:0] self_id;
    logic [NP:0]   grant;
    logic [IDW-1:0] owner_id;
    logic          self_granted;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mp_bus_arbiter #(.NUM_PROC(NP)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .proc_req     (proc_req),
        .host_req     (host_req),
        .lock         (lock),
        .rotate_mode  (rotate_mode),
        .xfer_done    (xfer_done),
        .self_id      (self_id),
        .grant        (grant),
        .owner_id     (owner_id),
        .self_granted (self_granted)
    );

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // who: 0 none, 1..NP processor, NP+1 host
    task automatic expect_owner(string req, int who);
        int exp_g;
        exp_g = (who == 0) ? 0 : (1 << (who - 1));
        chk(req, "grant", int'(grant), exp_g);
        chk(req, "owner_id", int'(owner_id), who);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; proc_req = '0; host_req = 1'b0; lock = 1'b0;
        rotate_mode = 1'b0; xfer_done = 1'b0; self_id = '0;
        step(3);
        expect_owner("R1", 0);
        chk("R1", "self_granted", int'(self_granted), 0);
        rst_n = 1'b1;
        step(1);
        expect_owner("R1", 0);
    endtask

    task automatic t_fixed_and_boundary();
        do_reset();
        self_id = IDW'(3);
        proc_req = 6'b010100;             // processors 3 and 5
        step(1);
        expect_owner("R2", 0);            // changeover cycle
        step(1);
        expect_owner("R4", 3);
        chk("R10", "self_granted", int'(self_granted), 1);
        proc_req = 6'b010101;             // processor 1 joins, no boundary
        step(2);
        expect_owner("R7", 3);
        xfer_done = 1'b1;
        step(1);
        xfer_done = 1'b0;
        expect_owner("R2", 0);
        step(1);
        expect_owner("R4", 1);
        chk("R10", "self_granted", int'(self_granted), 0);
        proc_req = 6'b010100;             // owner releases
        step(1);
        expect_owner("R8", 0);
        step(1);
        expect_owner("R8", 3);
        proc_req = '0;
        step(1);
        expect_owner("R8", 0);
        step(1);
        expect_owner("R8", 0);
    endtask

    task automatic t_fixed_hold();
        do_reset();
        proc_req = '1;
        xfer_done = 1'b1;
        step(2);
        expect_owner("R4", 1);
        step(4);
        expect_owner("R4", 1);
    endtask

    task automatic t_rotate();
        do_reset();
        rotate_mode = 1'b1;
        proc_req = '1;
        xfer_done = 1'b1;
        step(2);
        expect_owner("R5", 1);
        for (int k = 1; k <= NP; k++) begin
            step(1);
            expect_owner("R2", 0);
            step(1);
            expect_owner("R5", (k % NP) + 1);
        end
    endtask

    task automatic t_host();
        do_reset();
        proc_req = 6'b000010;             // processor 2
        step(2);
        expect_owner("R4", 2);
        host_req = 1'b1;
        step(2);
        expect_owner("R7", 2);
        xfer_done = 1'b1;
        step(1);
        expect_owner("R6", 0);
        step(1);
        expect_owner("R6", NP + 1);
        proc_req = 6'b000011;
        step(2);
        expect_owner("R6", NP + 1);
    endtask

    task automatic t_lock();
        do_reset();
        proc_req = 6'b001000;             // processor 4
        step(2);
        expect_owner("R4", 4);
        lock = 1'b1; host_req = 1'b1; xfer_done = 1'b1;
        proc_req = 6'b000001;             // owner drops, processor 1 asks
        for (int k = 0; k < 3; k++) begin
            step(1);
            expect_owner("R9", 4);
        end
        lock = 1'b0;
        step(1);
        expect_owner("R9", 0);
        step(1);
        expect_owner("R9", NP + 1);
        // lock while idle blocks any grant
        do_reset();
        lock = 1'b1;
        proc_req = 6'b000010;
        for (int k = 0; k < 3; k++) begin
            step(1);
            expect_owner("R9", 0);
        end
        lock = 1'b0;
        step(1);
        expect_owner("R2", 0);
        step(1);
        expect_owner("R9", 2);
    endtask

    initial begin
        t_fixed_and_boundary();
        t_fixed_hold();
        t_rotate();
        t_host();
        t_lock();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule